// File: doc/BRIEF.md
# Multi-Level Page-Table Walker with Atomic Flag Write-Back

This block turns a virtual address into a physical address by fetching one 64-bit table entry per level, starting from a root table. Each level consumes nine bits of the virtual address. The walk stops early when a large-page bit is found at the 1 GB or 2 MB level. On the way down it builds a combined permission set from every entry (writable, user-accessible, executable). When an entry still lacks its accessed flag, or a write reaches a leaf whose dirty flag is clear, the walker marks the entry in memory. It does this with a 32-bit compare-and-swap on the low word of the entry, not with a plain store.

If another agent changed the entry between the fetch and the swap, the value the swap returns matches neither the value the walker expected nor the value it meant to write. The walker then drops everything it gathered and starts again at the root. The result is therefore always built from entries whose flags were set atomically with the present and permission check.

Requests and results move over valid/ready channels. A request is taken only while `req_ready` is high, which is only when no walk is running. A result stays on `res_*` until `res_ready` is seen high at a clock edge. On the memory side the walker presents one request at a time and holds it until `mem_req_ready` is high. It then waits for exactly one `mem_rsp_valid` pulse, which must not arrive while no request is outstanding. `root_base` and `nx_enable` must stay stable during a walk.

Top module: `pt_walker`

## Requirements
- R1: The entry address at each level is the 4 KB-aligned table base with nine virtual-address bits, shifted left by 3, added in. The root level takes bits 47:39 and each lower level takes the next nine bits down, ending with bits 20:12 at the 4 KB level. The first read of every walk goes to `root_base` plus the root index times 8.
- R2: A present, legal entry above the leaf with its accessed flag (bit 5) clear is marked by a compare-and-swap before the next level is read.
- R3: At a leaf, one compare-and-swap sets the accessed flag. The same swap also sets dirty (bit 6) when the access is a write and dirty is clear. No swap is issued when the flags already needed are set.
- R4: A swap request uses operation code 2'b10 (reads use 2'b01). Its compare value is the low 32 bits of the entry as read, and its replacement is that value OR the flags being set.
- R5: When the returned old word equals the compare value or the replacement, the walk continues with the replacement as the entry's low word. Any other returned value restarts the walk at the root level with fresh permissions.
- R6: Bit 7 set at the 1 GB level ends the walk with size code 2 and keeps address bits 29:0 from the virtual address. At the 2 MB level it gives size code 1 and keeps bits 20:0. A 4 KB leaf gives size code 0 and keeps bits 11:0. The upper bits come from the leaf entry.
- R7: `res_w` is the AND of bit 1 over all entries walked, `res_u` is the AND of bit 2, and `res_x` is the AND of the inverse of bit 63.
- R8: With `nx_enable` low, bit 63 set in any entry is a reserved-bit fault. With it high, that bit only clears execute permission.
- R9: An entry with any of bits 62 down to the physical-address width set gives a fault with `res_err` = {1, user, write, 1}, listed from bit 3 down to bit 0. No swap is issued for that entry.
- R10: An entry with bit 0 clear gives a fault with `res_err` = {0, user, write, 0}, listed from bit 3 down to bit 0.
- R11: The walker holds a memory request unchanged until `mem_req_ready` and holds a result unchanged until `res_ready`. `req_ready` is high only while idle.
- R12: Bit 7 set in a root-level entry is a reserved-bit fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 52 | Physical base of the root table |
| nx_enable | input | 1 | Treat bit 63 as no-execute rather than reserved |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 52 | Physical address (zero on fault) |
| res_size | output | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| res_fault | output | 1 | Walk ended in a fault |
| res_err | output | 4 | Fault cause: bit 3 reserved, bit 2 user, bit 1 write, bit 0 present |
| res_w | output | 1 | Combined write permission |
| res_u | output | 1 | Combined user permission |
| res_x | output | 1 | Combined execute permission |
| mem_req_valid | output | 1 | Memory operation requested |
| mem_req_ready | input | 1 | Memory accepts the operation |
| mem_req_op | output | 2 | 2'b01 read 64 bits, 2'b10 compare-and-swap low 32 bits |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_cmp | output | 32 | Expected low word for a swap |
| mem_req_swap | output | 32 | Replacement low word for a swap |
| mem_rsp_valid | input | 1 | Response to the outstanding operation |
| mem_rsp_data | input | 64 | Read data, or the old low word for a swap |

## Verification
The hardest case to reach from the ports is a lost race: an entry that changes between the walker's read and its swap. No ordinary memory does that on its own. The bench's memory model can be armed with one address and one low word, and it writes that word into the entry just before it carries out a swap to that address. Two outcomes follow. If the injected word matches neither the compare value nor the replacement, the bench checks that the walk restarts from the root, which shows up as twice the number of reads, and that the result comes from the new entry. If the injected word equals the replacement, the bench checks that the walk continues without a restart.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    WS_IDLE, WS_RD_REQ, WS_RD_WAIT, WS_STEP, WS_CAS_REQ, WS_CAS_WAIT, WS_DONE
  } walk_state_e;

  localparam logic [1:0] MOP_READ64 = 2'b01;
  localparam logic [1:0] MOP_CAS32  = 2'b10;

  localparam int FB_PRESENT = 0;
  localparam int FB_WRITE   = 1;
  localparam int FB_USER    = 2;
  localparam int FB_ACC     = 5;
  localparam int FB_DIRTY   = 6;
  localparam int FB_LARGE   = 7;
  localparam int FB_NOEXEC  = 63;

  typedef enum logic [1:0] {
    PGS_4K = 2'd0, PGS_2M = 2'd1, PGS_1G = 2'd2
  } pg_size_e;

endpackage

// File: rtl/pt_addr_unit.sv
module pt_addr_unit
  import pt_walker_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [PA_W-1:0]  leaf_entry,
  input  pg_size_e         leaf_size,
  output logic [PA_W-1:0]  entry_addr,
  output logic [PA_W-1:0]  phys_addr
);

  logic [IDX_W-1:0] idx_tab [LEVELS];
  logic [PA_W-1:0]  off_mask [4];
  logic [PA_W-1:0]  va_ext;
  logic [PA_W-1:0]  sel_mask;
  logic             unused_base;

  // one 9-bit index slice per table level
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tab[g] = va[PG_SHIFT + IDX_W*g +: IDX_W];
  end

  // page-offset masks per size code; code 3 falls back to 4 KB
  for (genvar s = 0; s < 4; s++) begin : g_mask
    localparam int OFF = PG_SHIFT + IDX_W * ((s == 3) ? 0 : s);
    assign off_mask[s] = (PA_W'(1) << OFF) - PA_W'(1);
  end

  assign va_ext      = {{(PA_W-VA_W){1'b0}}, va};
  assign entry_addr  = {tbl_base[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}}
                     | (PA_W'(idx_tab[lvl]) << 3);
  assign sel_mask    = off_mask[leaf_size];
  assign phys_addr   = (leaf_entry & ~sel_mask) | (va_ext & sel_mask);
  assign unused_base = ^tbl_base[PG_SHIFT-1:0];

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
#(
  parameter int PA_W     = 52,
  parameter int LEVELS   = 4,
  parameter int PG_SHIFT = 12,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [63:0]      entry,
  input  logic [LVL_W-1:0] lvl,
  input  logic             is_write,
  input  logic             nx_on,
  output logic             present,
  output logic             rsvd,
  output logic             leaf,
  output pg_size_e         size,
  output logic             need_upd,
  output logic [31:0]      set_bits,
  output logic [PA_W-1:0]  next_base
);

  logic large_ok;
  logic acc_need;
  logic dirty_need;
  logic unused_bits;

  // large pages are legal only at the 2 MB and 1 GB levels
  assign large_ok   = (int'(lvl) == 1) || (int'(lvl) == 2);
  assign present    = entry[FB_PRESENT];
  assign rsvd       = (|entry[62:PA_W])
                    | (entry[FB_NOEXEC] & ~nx_on)
                    | (entry[FB_LARGE] & (int'(lvl) > 2));
  assign leaf       = (lvl == '0) || (entry[FB_LARGE] && large_ok);
  assign acc_need   = ~entry[FB_ACC];
  assign dirty_need = leaf & is_write & ~entry[FB_DIRTY];
  assign need_upd   = acc_need | dirty_need;
  assign set_bits   = (32'h1 << FB_ACC) | (dirty_need ? (32'h1 << FB_DIRTY) : 32'h0);
  assign next_base  = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};

  always_comb begin
    if (entry[FB_LARGE] && int'(lvl) == 2)      size = PGS_1G;
    else if (entry[FB_LARGE] && int'(lvl) == 1) size = PGS_2M;
    else                                        size = PGS_4K;
  end

  assign unused_bits = ^{entry[11:8], entry[4:3]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_base,
  input  logic            nx_enable,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [PA_W-1:0] res_pa,
  output logic [1:0]      res_size,
  output logic            res_fault,
  output logic [3:0]      res_err,
  output logic            res_w,
  output logic            res_u,
  output logic            res_x,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [1:0]      mem_req_op,
  output logic [PA_W-1:0] mem_req_addr,
  output logic [31:0]     mem_req_cmp,
  output logic [31:0]     mem_req_swap,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data
);

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_e     st;
  logic [VA_W-1:0] va_q;
  logic            wr_q, us_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0] base_q;
  logic [63:0]     ent_q;
  logic            pw_q, pu_q, px_q;

  logic            e_present, e_rsvd, e_leaf, e_need;
  pg_size_e        e_size;
  logic [31:0]     e_set;
  logic [PA_W-1:0] e_next;
  logic [PA_W-1:0] ent_addr, leaf_pa;
  logic            nw, nu, nx;
  logic            cas_ok;

  pt_entry_eval #(.PA_W(PA_W), .LEVELS(LEVELS), .PG_SHIFT(PG_SHIFT)) u_eval (
    .entry(ent_q), .lvl(lvl_q), .is_write(wr_q), .nx_on(nx_enable),
    .present(e_present), .rsvd(e_rsvd), .leaf(e_leaf), .size(e_size),
    .need_upd(e_need), .set_bits(e_set), .next_base(e_next)
  );

  pt_addr_unit #(.VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
                 .PG_SHIFT(PG_SHIFT)) u_addr (
    .va(va_q), .lvl(lvl_q), .tbl_base(base_q), .leaf_entry(ent_q[PA_W-1:0]),
    .leaf_size(e_size), .entry_addr(ent_addr), .phys_addr(leaf_pa)
  );

  assign req_ready     = (st == WS_IDLE);
  assign res_valid     = (st == WS_DONE);
  assign mem_req_valid = (st == WS_RD_REQ) || (st == WS_CAS_REQ);
  assign mem_req_op    = (st == WS_CAS_REQ) ? MOP_CAS32 : MOP_READ64;
  assign mem_req_addr  = ent_addr;
  assign mem_req_cmp   = ent_q[31:0];
  assign mem_req_swap  = ent_q[31:0] | e_set;
  assign cas_ok        = (mem_rsp_data[31:0] == mem_req_cmp) ||
                         (mem_rsp_data[31:0] == mem_req_swap);

  // permissions after folding in the current entry
  assign nw = pw_q & ent_q[FB_WRITE];
  assign nu = pu_q & ent_q[FB_USER];
  assign nx = px_q & ~ent_q[FB_NOEXEC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= WS_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      us_q      <= 1'b0;
      lvl_q     <= TOP_LVL;
      base_q    <= '0;
      ent_q     <= '0;
      pw_q      <= 1'b1;
      pu_q      <= 1'b1;
      px_q      <= 1'b1;
      res_pa    <= '0;
      res_size  <= 2'd0;
      res_fault <= 1'b0;
      res_err   <= 4'd0;
      res_w     <= 1'b0;
      res_u     <= 1'b0;
      res_x     <= 1'b0;
    end else begin
      case (st)
        WS_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          us_q   <= req_user;
          lvl_q  <= TOP_LVL;
          base_q <= root_base;
          pw_q   <= 1'b1;
          pu_q   <= 1'b1;
          px_q   <= 1'b1;
          st     <= WS_RD_REQ;
        end
        WS_RD_REQ: if (mem_req_ready) st <= WS_RD_WAIT;
        WS_RD_WAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          st    <= WS_STEP;
        end
        WS_STEP: begin
          if (!e_present || e_rsvd) begin
            res_fault <= 1'b1;
            res_err   <= {e_present, us_q, wr_q, e_present};
            res_pa    <= '0;
            res_size  <= 2'd0;
            res_w     <= 1'b0;
            res_u     <= 1'b0;
            res_x     <= 1'b0;
            st        <= WS_DONE;
          end else if (e_need) begin
            st <= WS_CAS_REQ;
          end else if (e_leaf) begin
            res_fault <= 1'b0;
            res_err   <= 4'd0;
            res_pa    <= leaf_pa;
            res_size  <= e_size;
            res_w     <= nw;
            res_u     <= nu;
            res_x     <= nx;
            st        <= WS_DONE;
          end else begin
            pw_q   <= nw;
            pu_q   <= nu;
            px_q   <= nx;
            base_q <= e_next;
            lvl_q  <= lvl_q - LVL_W'(1);
            st     <= WS_RD_REQ;
          end
        end
        WS_CAS_REQ: if (mem_req_ready) st <= WS_CAS_WAIT;
        WS_CAS_WAIT: if (mem_rsp_valid) begin
          if (cas_ok) begin
            ent_q[31:0] <= mem_req_swap;
            st          <= WS_STEP;
          end else begin
            lvl_q  <= TOP_LVL;
            base_q <= root_base;
            pw_q   <= 1'b1;
            pu_q   <= 1'b1;
            px_q   <= 1'b1;
            st     <= WS_RD_REQ;
          end
        end
        WS_DONE: if (res_ready) st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end

  // R11: memory request held until taken
  assert_mreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_op) && $stable(mem_req_addr) && $stable(mem_req_swap));

  // R11: result held until consumed
  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=>
      res_valid && $stable(res_pa) && $stable(res_err) && $stable(res_fault));

  // R11: a response only arrives while one is awaited
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (st == WS_RD_WAIT || st == WS_CAS_WAIT));

  // R4: a swap only adds the accessed/dirty flags
  assert_cas_flags_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op == MOP_CAS32 |->
      ((mem_req_cmp ^ mem_req_swap) & ~32'h60) == 32'h0 && mem_req_cmp != mem_req_swap);

  // R5: a lost swap restarts at the root
  assert_restart_root_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == WS_CAS_WAIT && mem_rsp_valid && !cas_ok |=>
      st == WS_RD_REQ && lvl_q == TOP_LVL && base_q == $past(root_base));

  // R6: a completed translation carries a legal size code and no cause bits
  assert_ok_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_size != 2'd3 && res_err == 4'd0);

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [51:0] root_base;
  logic        nx_enable;
  logic        req_valid, req_ready, req_write, req_user;
  logic [47:0] req_va;
  logic        res_valid, res_ready, res_fault, res_w, res_u, res_x;
  logic [51:0] res_pa;
  logic [1:0]  res_size;
  logic [3:0]  res_err;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [1:0]  mem_req_op;
  logic [51:0] mem_req_addr;
  logic [31:0] mem_req_cmp, mem_req_swap;
  logic [63:0] mem_rsp_data;

  always #2 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .nx_enable(nx_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_size(res_size), .res_fault(res_fault), .res_err(res_err),
    .res_w(res_w), .res_u(res_u), .res_x(res_x),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_cmp(mem_req_cmp), .mem_req_swap(mem_req_swap),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [63:0] mem [logic [51:0]];
  int          n_rd, n_cas, n_ops, cyc;
  logic [1:0]  op_seq [16];
  logic [51:0] first_addr, last_rd;
  logic [31:0] last_cmp, last_swap;
  logic        inj_arm;
  logic [51:0] inj_addr;
  logic [31:0] inj_val;

  // captured result
  logic [51:0] g_pa;
  logic [1:0]  g_sz;
  logic        g_f, g_w, g_u, g_x;
  logic [3:0]  g_err;

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory: decides ready, then handles a handshake at each falling edge
  initial begin : mem_model
    logic        pend;
    logic [63:0] pend_data;
    logic [31:0] old;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    pend = 1'b0;
    pend_data = '0;
    cyc = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      cyc++;
      mem_req_ready = (cyc % 3) != 0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
        pend = 1'b0;
      end else if (mem_req_valid && mem_req_ready) begin
        if (n_ops < 16) op_seq[n_ops] = mem_req_op;
        if (n_ops == 0) first_addr = mem_req_addr;
        n_ops++;
        if (mem_req_op == 2'b01) begin
          n_rd++;
          last_rd   = mem_req_addr;
          pend_data = rd(mem_req_addr);
        end else begin
          n_cas++;
          if (inj_arm && mem_req_addr == inj_addr) begin
            mem[mem_req_addr] = {rd(mem_req_addr) >> 32, inj_val};
            inj_arm = 1'b0;
          end
          old = rd(mem_req_addr)[31:0];
          if (old == mem_req_cmp)
            mem[mem_req_addr] = {rd(mem_req_addr)[63:32], mem_req_swap};
          last_cmp  = mem_req_cmp;
          last_swap = mem_req_swap;
          pend_data = {32'h0, old};
        end
        pend = 1'b1;
      end
    end
  end

  task automatic walk(input logic [47:0] va, input logic wr, input logic us);
    int t;
    n_rd = 0; n_cas = 0; n_ops = 0;
    req_va = va; req_write = wr; req_user = us; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!res_valid && t < 3000) begin
      @(negedge clk);
      t++;
    end
    g_pa = res_pa; g_sz = res_size; g_f = res_fault; g_err = res_err;
    g_w = res_w; g_u = res_u; g_x = res_x;
    if (!res_valid) chk("walk timeout", 0, 1);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [47:0] va;
    logic        wr;
    logic        us;
    logic        flt;
    logic [3:0]  err;
    logic [51:0] pa;
    logic [1:0]  sz;
    logic        w;
    logic        u;
    logic        x;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{48'h1123,       1'b0, 1'b1, 1'b0, 4'h0, 52'hABC123,   2'd0, 1'b1, 1'b1, 1'b1}, // R1 R2 R3
    '{48'h1008,       1'b1, 1'b0, 1'b0, 4'h0, 52'hABC008,   2'd0, 1'b1, 1'b1, 1'b1}, // R3 dirty
    '{48'h212345,     1'b0, 1'b0, 1'b0, 4'h0, 52'h612345,   2'd1, 1'b1, 1'b0, 1'b1}, // R6 2M, R7
    '{48'h41234567,   1'b0, 1'b1, 1'b0, 4'h0, 52'h41234567, 2'd2, 1'b0, 1'b1, 1'b0}, // R6 1G, R7, R8
    '{48'h2000,       1'b1, 1'b1, 1'b1, 4'h6, 52'h0,        2'd0, 1'b0, 1'b0, 1'b0}, // R10
    '{48'h3000,       1'b0, 1'b0, 1'b1, 4'h9, 52'h0,        2'd0, 1'b0, 1'b0, 1'b0}, // R9
    '{48'h8000000000, 1'b0, 1'b0, 1'b1, 4'h9, 52'h0,        2'd0, 1'b0, 1'b0, 1'b0}, // R12
    '{48'h4abc,       1'b0, 1'b1, 1'b0, 4'h0, 52'h7abc,     2'd0, 1'b0, 1'b1, 1'b1}  // R7
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; root_base = 52'h1000; nx_enable = 1'b1;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0;
    res_ready = 1'b1; inj_arm = 1'b0; inj_addr = '0; inj_val = '0;
    n_rd = 0; n_cas = 0; n_ops = 0;
    mem[52'h1000] = 64'h2007;               // root[0], accessed clear
    mem[52'h1008] = 64'h20A1;               // root[1], large bit at root
    mem[52'h2000] = 64'h3027;
    mem[52'h2008] = 64'h8000_0000_4000_00A5; // 1G, no write, no-exec
    mem[52'h3000] = 64'h4027;
    mem[52'h3008] = 64'h6000A3;             // 2M, no user
    mem[52'h4008] = 64'hABC007;
    mem[52'h4018] = 64'h1000_0000_0000_5001; // reserved high bit
    mem[52'h4020] = 64'h7025;
    mem[52'h4028] = 64'h8007;
    mem[52'h4030] = 64'hA001;

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset req_ready", req_ready, 1);
    chk("R11 reset res_valid", res_valid, 0);
    chk("R11 reset mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      walk(VECS[i].va, VECS[i].wr, VECS[i].us);
      chk($sformatf("R9 R10 vec%0d fault", i), g_f, VECS[i].flt);
      chk($sformatf("R9 R10 vec%0d err", i), g_err, VECS[i].err);
      if (!VECS[i].flt) begin
        chk($sformatf("R6 vec%0d pa", i), g_pa, VECS[i].pa);
        chk($sformatf("R6 vec%0d size", i), g_sz, VECS[i].sz);
        chk($sformatf("R7 vec%0d perms", i), {g_w, g_u, g_x},
            {VECS[i].w, VECS[i].u, VECS[i].x});
      end
      case (i)
        0: begin
          chk("R1 first read addr", first_addr, 52'h1000);
          chk("R1 leaf read addr", last_rd, 52'h4008);
          chk("R2 swap before level-2 read", op_seq[1], 2'b10);
          chk("R2 root accessed set", rd(52'h1000) & 64'h20, 64'h20);
          chk("R4 leaf swap cmp", last_cmp, 32'h00ABC007);
          chk("R4 leaf swap value", last_swap, 32'h00ABC027);
          chk("R3 swap count", n_cas, 2);
        end
        1: begin
          chk("R3 dirty swap value", last_swap, 32'h00ABC067);
          chk("R3 leaf dirty in memory", rd(52'h4008) & 64'h60, 64'h60);
        end
        2: chk("R3 no swap when flags set", n_cas, 0);
        5: begin
          chk("R9 no swap on reserved", n_cas, 0);
          chk("R9 entry untouched", rd(52'h4018), 64'h1000_0000_0000_5001);
        end
        6: chk("R1 root index from bits 47:39", first_addr, 52'h1008);
        default: ;
      endcase
    end

    // R8: no-execute bit becomes reserved
    nx_enable = 1'b0;
    walk(48'h41234567, 1'b0, 1'b1);
    chk("R8 nx off fault", g_f, 1);
    chk("R8 nx off err", g_err, 4'hD);
    nx_enable = 1'b1;

    // R5: conflicting change forces a restart from the root
    inj_arm = 1'b1; inj_addr = 52'h4028; inj_val = 32'h9027;
    walk(48'h5000, 1'b0, 1'b1);
    chk("R5 restart reads", n_rd, 8);
    chk("R5 restart swaps", n_cas, 1);
    chk("R5 restart result pa", g_pa, 52'h9000);
    chk("R5 restart no fault", g_f, 0);

    // R5: other agent already set the same flag, walk continues
    inj_arm = 1'b1; inj_addr = 52'h4030; inj_val = 32'hA021;
    walk(48'h6000, 1'b0, 1'b0);
    chk("R5 benign race reads", n_rd, 4);
    chk("R5 benign race pa", g_pa, 52'hA000);
    chk("R7 benign race perms", {g_w, g_u, g_x}, 3'b001);

    // R11: result held under back-pressure
    res_ready = 1'b0;
    walk(48'h4abc, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R11 held valid", res_valid, 1);
    chk("R11 held pa", res_pa, 52'h7abc);
    chk("R11 busy not ready", req_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", res_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule